// File: doc/BRIEF.md
# Periodic Countdown Timer

A 32-bit down-counting timer with a small word-addressed register window and one level interrupt. Software writes a period, which is stored and copied straight into the live counter. Command bits in the control word then start or halt counting. While it runs, the counter drops by one on every clock. When it expires it raises a timeout flag. In auto-reload mode it refills from the stored period and keeps going. In one-shot mode it parks at zero and stops.

The live count can be read at any time through the snapshot word. The timeout flag is cleared by any write to the status word, whatever data is written. The interrupt output is the timeout flag gated by an enable bit in the control word. Reads are combinational from the address. A write takes effect at the clock edge where `we_i` is high.

Top module: `cdt_timer`

## Requirements
- R1: After reset every register reads zero, the counter is stopped and `irq_o` is low.
- R2: A write to offset 0x8 stores the period. The same write loads the value into the counter at that edge. Offset 0x8 reads back the period and offset 0xC reads back the live count.
- R3: A control write (offset 0x4) with bit 2 set and bit 3 clear starts the counter. Status bit 1 then reads 1, and each following clock lowers the count by one.
- R4: A control write with bit 3 set halts the counter and freezes the count. Bit 3 wins when bits 2 and 3 are both set.
- R5: The counter expires on the clock where it is running with a count of 1 or 0, so a period P ≥ 1 expires P clocks after the start edge. Expiry sets status bit 0. When control bit 1 is clear, expiry leaves the count at 0 and the counter stopped.
- R6: When control bit 1 is set, expiry reloads the count from the stored period and counting continues. The timeout flag is set every P clocks.
- R7: Any write to offset 0x0 clears status bit 0, whatever the data. An expiry in the same cycle takes precedence and leaves the flag set.
- R8: `irq_o` is high exactly when status bit 0 and control bit 0 are both 1.
- R9: A control write stores all 32 bits, and offset 0x4 reads them back unchanged.
- R10: Writes to offset 0xC, and writes to offsets from 0x10 upward, change no state. Reads from offsets from 0x10 upward return zero.
- R11: A period of zero expires on the first clock after the start edge. In reload mode it then expires on every clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| we_i | input | 1 | Write strobe for the current address |
| addr_i | input | 6 | Byte address; bits 1:0 are ignored |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for `addr_i`, combinational |
| irq_o | output | 1 | Level interrupt |

## Verification
The counter is run with several periods in both one-shot and reload mode: a long period, a short period of three, and a period of zero. These show whether expiry falls on the right clock and whether reload refills from the stored period rather than restarting at an off-by-one value. Control words with start only, stop only, and both bits set separate the stop priority from plain halting. Status writes are placed both on quiet cycles and on expiry cycles, to tell clear-wins from set-wins. Writes to the snapshot and unmapped offsets are followed by reads of every register to prove nothing moved.

// File: rtl/cdt_pkg.sv
package cdt_pkg;
  localparam int ST_TO    = 0;
  localparam int ST_RUN   = 1;
  localparam int CT_ITO   = 0;
  localparam int CT_CONT  = 1;
  localparam int CT_START = 2;
  localparam int CT_STOP  = 3;

  typedef enum logic [1:0] {
    REG_STAT = 2'd0,
    REG_CTRL = 2'd1,
    REG_PER  = 2'd2,
    REG_SNAP = 2'd3
  } reg_idx_e;
endpackage

// File: rtl/cdt_decode.sv
module cdt_decode
  import cdt_pkg::*;
#(
  parameter int ADDR_W = 6
) (
  input  logic [ADDR_W-1:0] addr_i,
  output logic              hit_o,
  output reg_idx_e          idx_o
);
  assign idx_o = reg_idx_e'(addr_i[3:2]);

  generate
    if (ADDR_W > 4) begin : g_wide
      assign hit_o = (addr_i[ADDR_W-1:4] == '0);
    end else begin : g_narrow
      assign hit_o = 1'b1;
    end
  endgenerate
endmodule

// File: rtl/cdt_counter.sv
module cdt_counter #(
  parameter int DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [DATA_W-1:0] load_val_i,
  input  logic              start_i,
  input  logic              stop_i,
  input  logic              cont_i,
  input  logic [DATA_W-1:0] reload_i,
  output logic [DATA_W-1:0] cnt_o,
  output logic              run_o,
  output logic              expire_o
);
  localparam logic [DATA_W-1:0] ONE = DATA_W'(1);

  logic [DATA_W-1:0] cnt_q;
  logic              run_q;

  // a stop in the same cycle freezes the count and suppresses expiry
  assign expire_o = run_q && !stop_i && (cnt_q <= ONE);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      run_q <= 1'b0;
    end else begin
      if (load_i)                cnt_q <= load_val_i;
      else if (expire_o)         cnt_q <= cont_i ? reload_i : '0;
      else if (run_q && !stop_i) cnt_q <= cnt_q - ONE;

      if (stop_i)                   run_q <= 1'b0;
      else if (start_i)             run_q <= 1'b1;
      else if (expire_o && !cont_i) run_q <= 1'b0;
    end
  end

  assign cnt_o = cnt_q;
  assign run_o = run_q;
endmodule

// File: rtl/cdt_timer.sv
module cdt_timer
  import cdt_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 6
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              irq_o
);
  logic              hit;
  reg_idx_e          idx;
  logic              wr_stat, wr_ctrl, wr_per;
  logic [DATA_W-1:0] ctrl_q, per_q, cnt_q;
  logic              to_q, run_q, expire;

  cdt_decode #(.ADDR_W(ADDR_W)) u_dec (
    .addr_i(addr_i),
    .hit_o (hit),
    .idx_o (idx)
  );

  assign wr_stat = we_i && hit && (idx == REG_STAT);
  assign wr_ctrl = we_i && hit && (idx == REG_CTRL);
  assign wr_per  = we_i && hit && (idx == REG_PER);

  cdt_counter #(.DATA_W(DATA_W)) u_cnt (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .load_i    (wr_per),
    .load_val_i(wdata_i),
    .start_i   (wr_ctrl && wdata_i[CT_START]),
    .stop_i    (wr_ctrl && wdata_i[CT_STOP]),
    .cont_i    (ctrl_q[CT_CONT]),
    .reload_i  (per_q),
    .cnt_o     (cnt_q),
    .run_o     (run_q),
    .expire_o  (expire)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q <= '0;
      per_q  <= '0;
      to_q   <= 1'b0;
    end else begin
      if (wr_ctrl) ctrl_q <= wdata_i;
      if (wr_per)  per_q  <= wdata_i;
      // expiry outranks a clearing write in the same cycle
      if (expire)       to_q <= 1'b1;
      else if (wr_stat) to_q <= 1'b0;
    end
  end

  always_comb begin
    rdata_o = '0;
    if (hit) begin
      unique case (idx)
        REG_STAT: begin
          rdata_o[ST_TO]  = to_q;
          rdata_o[ST_RUN] = run_q;
        end
        REG_CTRL: rdata_o = ctrl_q;
        REG_PER:  rdata_o = per_q;
        REG_SNAP: rdata_o = cnt_q;
        default:  rdata_o = '0;
      endcase
    end
  end

  assign irq_o = to_q && ctrl_q[CT_ITO];
endmodule

// File: rtl/cdt_checker.sv
module cdt_checker #(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 6
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              we_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic [DATA_W-1:0] wdata_i,
  input logic [DATA_W-1:0] cnt,
  input logic              run,
  input logic              to,
  input logic              expire,
  input logic              cont
);
  localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(4);
  localparam logic [ADDR_W-1:0] A_PER  = ADDR_W'(8);
  localparam logic [DATA_W-1:0] ONE    = DATA_W'(1);

  p_load_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && addr_i == A_PER) |=> cnt == $past(wdata_i));

  p_step_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run && cnt > ONE && !we_i) |=> cnt == $past(cnt) - ONE);

  p_stop_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && addr_i == A_CTRL && wdata_i[3]) |=> !run);

  p_flag_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    expire |=> to);

  p_oneshot_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (expire && !cont && !(we_i && (addr_i == A_CTRL || addr_i == A_PER)))
      |=> (!run && cnt == '0));

  p_clear_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && addr_i == A_STAT && !expire) |=> !to);
endmodule

bind cdt_timer cdt_checker #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_chk (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .we_i   (we_i),
  .addr_i (addr_i),
  .wdata_i(wdata_i),
  .cnt    (cnt_q),
  .run    (run_q),
  .to     (to_q),
  .expire (expire),
  .cont   (ctrl_q[1])
);

// File: tb/cdt_timer_test.sv
`timescale 1ns/1ps
module cdt_timer_test;
  localparam int DW = 32;
  localparam int AW = 6;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          we;
  logic [AW-1:0] addr;
  logic [DW-1:0] wd;
  logic [DW-1:0] rd;
  logic          irq;

  always #4 clk = ~clk;

  cdt_timer #(.DATA_W(DW), .ADDR_W(AW)) uut (
    .clk_i(clk), .rst_ni(rst_n), .we_i(we), .addr_i(addr),
    .wdata_i(wd), .rdata_o(rd), .irq_o(irq)
  );

  // behavioural reference state
  longint m_cnt, m_per, m_ctrl;
  bit     m_run, m_to;
  int     n_cmp = 0, n_bad = 0;
  string  req = "R1";

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_cnt = 0; m_per = 0; m_ctrl = 0; m_run = 0; m_to = 0;
    end else begin
      longint nc, np, nt;
      bit nr, nto, mapped, stopw, fire;
      int sel;
      mapped = (addr >> 4) == 0;
      sel    = (addr >> 2) & 3;
      stopw  = we && mapped && sel == 1 && wd[3];
      fire   = m_run && !stopw && m_cnt <= 1;
      nc = m_cnt; np = m_per; nt = m_ctrl; nr = m_run; nto = m_to;
      if (fire) begin
        if (m_ctrl[1]) nc = m_per;
        else begin nc = 0; nr = 0; end
      end else if (m_run && !stopw) nc = (m_cnt - 1) & 64'hFFFF_FFFF;
      if (we && mapped) begin
        if (sel == 0) nto = 0;
        if (sel == 1) begin
          nt = wd;
          if (wd[3]) nr = 0;
          else if (wd[2]) nr = 1;
        end
        if (sel == 2) begin np = wd; nc = wd; end
      end
      if (fire) nto = 1;
      m_cnt = nc; m_per = np; m_ctrl = nt; m_run = nr; m_to = nto;
    end
  end

  function automatic longint m_read(logic [AW-1:0] a);
    if ((a >> 4) != 0) return 0;
    case ((a >> 2) & 3)
      0: return {m_run, m_to};
      1: return m_ctrl;
      2: return m_per;
      default: return m_cnt;
    endcase
  endfunction

  task automatic check();
    longint exp_rd;
    bit exp_irq;
    exp_rd  = m_read(addr);
    exp_irq = m_to && m_ctrl[0];
    n_cmp++;
    if (rd !== exp_rd[DW-1:0]) begin
      n_bad++;
      $display("FAIL %s addr=%0h rdata actual=%0h expected=%0h", req, addr, rd, exp_rd);
    end
    n_cmp++;
    if (irq !== exp_irq) begin
      n_bad++;
      $display("FAIL %s irq actual=%0b expected=%0b", req, irq, exp_irq);
    end
  endtask

  task automatic cyc(input bit w, input logic [AW-1:0] a, input logic [DW-1:0] d);
    @(negedge clk);
    check();
    we = w; addr = a; wd = d;
  endtask

  task automatic idle(input int n, input logic [AW-1:0] a);
    for (int i = 0; i < n; i++) cyc(1'b0, a, '0);
  endtask

  task automatic sweep();
    idle(1, 6'h00); idle(1, 6'h04); idle(1, 6'h08); idle(1, 6'h0C);
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog actual=hung expected=done");
    summary();
    $finish;
  end

  initial begin
    rst_n = 1'b0; we = 1'b0; addr = '0; wd = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    req = "R1"; sweep();
    req = "R9"; cyc(1, 6'h04, 32'hA5C3_0F02); sweep();
    cyc(1, 6'h04, 32'h0000_0000); sweep();
    req = "R2"; cyc(1, 6'h08, 32'd9); sweep();
    req = "R3"; cyc(1, 6'h04, 32'h5); idle(4, 6'h0C); idle(2, 6'h00);
    req = "R5"; idle(6, 6'h0C); sweep();
    req = "R8"; idle(2, 6'h00);
    req = "R7"; cyc(1, 6'h00, 32'hDEAD_0000); sweep();
    req = "R8"; cyc(1, 6'h04, 32'h0); idle(1, 6'h00);
    req = "R6"; cyc(1, 6'h08, 32'd3); cyc(1, 6'h04, 32'h7); idle(10, 6'h0C);
    idle(3, 6'h00);
    req = "R7";
    for (int i = 0; i < 8; i++) cyc(1, 6'h00, 32'h0);
    idle(2, 6'h00);
    req = "R4"; cyc(1, 6'h04, 32'hA); idle(4, 6'h0C); sweep();
    cyc(1, 6'h04, 32'h7); idle(2, 6'h0C);
    cyc(1, 6'h04, 32'hE); idle(4, 6'h0C); sweep();
    req = "R10"; cyc(1, 6'h0C, 32'h1234_5678); sweep();
    cyc(1, 6'h10, 32'hFFFF_FFFF); cyc(1, 6'h24, 32'h5); cyc(1, 6'h3C, 32'hF);
    idle(1, 6'h10); idle(1, 6'h20); idle(1, 6'h3C); sweep();
    req = "R11"; cyc(1, 6'h00, 32'h0); cyc(1, 6'h04, 32'h1); cyc(1, 6'h08, 32'h0);
    cyc(1, 6'h04, 32'h5); idle(3, 6'h00); sweep();
    cyc(1, 6'h04, 32'h7); idle(4, 6'h00); sweep();
    cyc(1, 6'h04, 32'h8); sweep();
    summary();
    $finish;
  end
endmodule